// File: doc/BRIEF.md
# ADC Self-Calibration Sequencer

This block runs an offset-then-gain self-calibration on an external delta-sigma converter. The converter is reached through a byte-wide command channel that feeds an SPI master, and the block watches the converter's active-low data-ready line. A start pulse latches the two configuration bytes that the application currently uses and raises the sync output. The sync output stays high for the whole procedure.

The calibration runs in two phases, offset first and then gain. Each phase first writes an input selection together with pulse-sync mode. It then waits a programmable number of cycles so that the analog input can settle. Next it stops continuous reading, issues a sync, restarts continuous reading and waits for data-ready to fall, which marks a settled filter. It then stops continuous reading again, issues the calibrate command for that phase, restarts continuous reading and waits for data-ready to fall once more. When both phases are done, the saved configuration is written back so that the application can return to continuous-sync operation.

Every data-ready wait is guarded by a timeout. If no falling edge arrives in time, the block aborts with an error.

Top module: `cal_seq`

## Requirements
- R1: Out of reset and while idle, busy, calDone, calError, cmdReq and syncOut are all low.
- R2: A calStart pulse in idle raises busy and syncOut on the following cycle, before the first command byte is transferred. syncOut stays high for as long as busy is high and falls together with busy.
- R3: A configuration write is four bytes: 0x41, 0x01, then configuration byte 0, then configuration byte 1. The offset phase writes SHORT_CFG0 and SHORT_CFG1.
- R4: After the configuration write and the settle delay, the block sends 0x11 (stop continuous read), 0x04 (sync) and 0x10 (start continuous read), in that order.
- R5: After every 0x10 byte the block issues no request until it has seen a high-to-low transition on drdyN. It then resumes with the next byte.
- R6: The offset phase continues with 0x11, 0x60 (offset calibrate) and 0x10, followed by a data-ready wait.
- R7: The gain phase starts only after the offset phase has finished. It writes FULL_CFG0 and FULL_CFG1, repeats the delay and settle steps, then sends 0x11, 0x61 (gain calibrate) and 0x10, followed by a wait.
- R8: Between the transfer of the last configuration byte of a phase and the transfer of its following 0x11, at least settleDelay clock cycles pass.
- R9: The run ends by writing 0x41, 0x01 and the origCfg0 and origCfg1 values latched at start. calDone is then set, and busy falls. A complete run is 24 bytes.
- R10: If drdyN does not fall within TMO_CYCLES cycles of a wait starting, calError is set, busy and syncOut fall, and no further byte is requested. A later start clears calError and calDone.
- R11: A calStart pulse, or a change on origCfg0 or origCfg1, while busy has no effect on the byte stream.
- R12: While cmdReq is high and cmdAck is low, cmdReq stays high and cmdByte keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| calStart | input | 1 | Start pulse, accepted only when idle |
| origCfg0 | input | 8 | Application configuration byte 0, latched at start |
| origCfg1 | input | 8 | Application configuration byte 1, latched at start |
| settleDelay | input | DLY_W | Cycles to wait after each input-selection write |
| cmdReq | output | 1 | A command byte is offered to the SPI master |
| cmdByte | output | 8 | Offered command byte |
| cmdAck | input | 1 | SPI master takes the byte in this cycle |
| drdyN | input | 1 | Converter data-ready, active low, asynchronous |
| syncOut | output | 1 | Converter sync pin, high throughout calibration |
| busy | output | 1 | Calibration in progress |
| calDone | output | 1 | Last run finished normally (sticky until next start) |
| calError | output | 1 | Last run aborted on timeout (sticky until next start) |

## Verification
A step counter that skips or repeats shows up at once at the command port. The byte stream would then be out of order, the wrong length, or would leave out the configuration write-back, and this is visible on the very next transfer. A wrong wait state shows up in one of two ways: either bytes are requested before data-ready has fallen, or the block hangs until the timeout raises calError. A fault in the delay or timeout counter changes the spacing between transfers, or the time until calError, by at least the programmed amount.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  // Command byte values understood by the converter
  localparam logic [7:0] CMD_WRITE_CFG  = 8'h41;  // register write, first address 1
  localparam logic [7:0] CMD_WRITE_CNT  = 8'h01;  // two registers follow
  localparam logic [7:0] CMD_STOP_RD    = 8'h11;
  localparam logic [7:0] CMD_SYNC       = 8'h04;
  localparam logic [7:0] CMD_START_RD   = 8'h10;
  localparam logic [7:0] CMD_CAL_OFFSET = 8'h60;
  localparam logic [7:0] CMD_CAL_GAIN   = 8'h61;

  localparam int STEP_W       = 5;
  localparam int PHASE_LEN    = 13;              // steps in one calibration phase
  localparam int RESTORE_BASE = 2 * PHASE_LEN;   // first step of the write-back
  localparam int LAST_STEP    = RESTORE_BASE + 4;

  typedef enum logic [1:0] {OP_SEND, OP_DELAY, OP_WAIT, OP_FINISH} opKind_t;
  typedef enum logic [1:0] {SRC_CODE, SRC_CFG0, SRC_CFG1} byteSrc_t;
  typedef enum logic [1:0] {BANK_SHORT, BANK_FULL, BANK_ORIG} cfgBank_t;

  typedef struct packed {
    opKind_t    kind;
    byteSrc_t   src;
    cfgBank_t   bank;
    logic [7:0] code;
  } stepInfo_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchCfg;
    logic syncSet;
    logic syncClr;
    logic loadDelay;
    logic loadTimeout;
  } dpStrobe_t;

  // Maps a step number to the operation it performs
  function automatic stepInfo_t decodeStep(input logic [STEP_W-1:0] step);
    stepInfo_t r;
    int s;
    int loc;
    logic gainPhase;
    s = int'(step);
    r.kind = OP_SEND;
    r.src  = SRC_CODE;
    r.bank = BANK_SHORT;
    r.code = 8'h00;
    if (s < RESTORE_BASE) begin
      gainPhase = (s >= PHASE_LEN);
      loc = gainPhase ? s - PHASE_LEN : s;
      r.bank = gainPhase ? BANK_FULL : BANK_SHORT;
      case (loc)
        0:       r.code = CMD_WRITE_CFG;
        1:       r.code = CMD_WRITE_CNT;
        2:       r.src  = SRC_CFG0;
        3:       r.src  = SRC_CFG1;
        4:       r.kind = OP_DELAY;
        5, 9:    r.code = CMD_STOP_RD;
        6:       r.code = CMD_SYNC;
        7, 11:   r.code = CMD_START_RD;
        10:      r.code = gainPhase ? CMD_CAL_GAIN : CMD_CAL_OFFSET;
        default: r.kind = OP_WAIT;   // steps 8 and 12 of a phase
      endcase
    end else begin
      r.bank = BANK_ORIG;
      loc = s - RESTORE_BASE;
      case (loc)
        0:       r.code = CMD_WRITE_CFG;
        1:       r.code = CMD_WRITE_CNT;
        2:       r.src  = SRC_CFG0;
        3:       r.src  = SRC_CFG1;
        default: r.kind = OP_FINISH;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
  import cal_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      calStart,
  input  logic      cmdAck,
  input  logic      cntZero,
  input  logic      drdyFall,
  output logic      cmdReq,
  output logic      busy,
  output logic      calDone,
  output logic      calError,
  output stepInfo_t curStep,
  output dpStrobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_COUNT} state_t;

  state_t              state;
  logic [STEP_W-1:0]   step;

  assign curStep = decodeStep(step);
  assign busy    = (state != ST_IDLE);
  assign cmdReq  = (state == ST_ISSUE) && (curStep.kind == OP_SEND);

  always_comb begin
    strobe = '0;
    case (state)
      ST_IDLE: begin
        strobe.latchCfg = calStart;
        strobe.syncSet  = calStart;
      end
      ST_ISSUE: begin
        strobe.loadDelay   = (curStep.kind == OP_DELAY);
        strobe.loadTimeout = (curStep.kind == OP_WAIT);
        strobe.syncClr     = (curStep.kind == OP_FINISH);
      end
      default: begin
        strobe.syncClr = (curStep.kind == OP_WAIT) && !drdyFall && cntZero;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      step     <= '0;
      calDone  <= 1'b0;
      calError <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (calStart) begin
            state    <= ST_ISSUE;
            step     <= '0;
            calDone  <= 1'b0;
            calError <= 1'b0;
          end
        end
        ST_ISSUE: begin
          case (curStep.kind)
            OP_SEND:   if (cmdAck) step <= step + 1'b1;
            OP_FINISH: begin
              state   <= ST_IDLE;
              calDone <= 1'b1;
            end
            default:   state <= ST_COUNT;
          endcase
        end
        default: begin
          if (curStep.kind == OP_WAIT) begin
            if (drdyFall) begin
              step  <= step + 1'b1;
              state <= ST_ISSUE;
            end else if (cntZero) begin
              calError <= 1'b1;
              state    <= ST_IDLE;
            end
          end else if (cntZero) begin
            step  <= step + 1'b1;
            state <= ST_ISSUE;
          end
        end
      endcase
    end
  end

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(calDone && calError)); // R10

  AST_ERR_FROM_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calError) |-> $past(state == ST_COUNT) && $past(curStep.kind == OP_WAIT)); // R10

  AST_WAIT_RESUMES: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COUNT) && (curStep.kind == OP_WAIT) && drdyFall
      |=> (state == ST_ISSUE) && cmdReq); // R5

  AST_DONE_AFTER_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calDone) |-> $past(step) == STEP_W'(LAST_STEP)); // R9

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    busy && calStart && !cmdAck && (state == ST_ISSUE) && (curStep.kind == OP_SEND)
      |=> $stable(step)); // R11

endmodule

// File: rtl/cal_seq_dp.sv
module cal_seq_dp
  import cal_seq_pkg::*;
#(
  parameter int         DLY_W       = 16,
  parameter int         CNT_W       = 20,
  parameter int         TMO_CYCLES  = 1000,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] SHORT_CFG0  = 8'h02,
  parameter logic [7:0] SHORT_CFG1  = 8'h18,
  parameter logic [7:0] FULL_CFG0   = 8'h02,
  parameter logic [7:0] FULL_CFG1   = 8'h10
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  stepInfo_t        curStep,
  input  logic [7:0]       origCfg0,
  input  logic [7:0]       origCfg1,
  input  logic [DLY_W-1:0] settleDelay,
  input  logic             drdyN,
  output logic [7:0]       cmdByte,
  output logic             cntZero,
  output logic             drdyFall,
  output logic             syncOut
);

  localparam logic [CNT_W-1:0] TMO_VAL = CNT_W'(TMO_CYCLES);

  logic [7:0]             savedCfg0;
  logic [7:0]             savedCfg1;
  logic [CNT_W-1:0]       cnt;
  logic [SYNC_STAGES:0]   drdyPipe;
  logic [7:0]             pick0;
  logic [7:0]             pick1;
  logic [7:0]             byteVal;

  // Data-ready synchroniser plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) drdyPipe <= '1;
    else       drdyPipe <= {drdyPipe[SYNC_STAGES-1:0], drdyN};
  end
  assign drdyFall = drdyPipe[SYNC_STAGES] && !drdyPipe[SYNC_STAGES-1];

  // Shared down-counter: settle delay or data-ready timeout
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   cnt <= '0;
    else if (strobe.loadDelay)   cnt <= CNT_W'(settleDelay);
    else if (strobe.loadTimeout) cnt <= TMO_VAL;
    else if (cnt != '0)          cnt <= cnt - 1'b1;
  end
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      savedCfg0 <= '0;
      savedCfg1 <= '0;
    end else if (strobe.latchCfg) begin
      savedCfg0 <= origCfg0;
      savedCfg1 <= origCfg1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               syncOut <= 1'b0;
    else if (strobe.syncSet) syncOut <= 1'b1;
    else if (strobe.syncClr) syncOut <= 1'b0;
  end

  always_comb begin
    case (curStep.bank)
      BANK_FULL: begin pick0 = FULL_CFG0; pick1 = FULL_CFG1; end
      BANK_ORIG: begin pick0 = savedCfg0; pick1 = savedCfg1; end
      default:   begin pick0 = SHORT_CFG0; pick1 = SHORT_CFG1; end
    endcase
    case (curStep.src)
      SRC_CFG0: byteVal = pick0;
      SRC_CFG1: byteVal = pick1;
      default:  byteVal = curStep.code;
    endcase
    cmdByte = (curStep.kind == OP_SEND) ? byteVal : 8'h00;
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    syncOut && !strobe.latchCfg |=> $stable(savedCfg0) && $stable(savedCfg1)); // R11

endmodule

// File: rtl/cal_seq.sv
module cal_seq
  import cal_seq_pkg::*;
#(
  parameter int         DLY_W       = 16,
  parameter int         TMO_CYCLES  = 1_000_000,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] SHORT_CFG0  = 8'h02,
  parameter logic [7:0] SHORT_CFG1  = 8'h18,
  parameter logic [7:0] FULL_CFG0   = 8'h02,
  parameter logic [7:0] FULL_CFG1   = 8'h10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             calStart,
  input  logic [7:0]       origCfg0,
  input  logic [7:0]       origCfg1,
  input  logic [DLY_W-1:0] settleDelay,
  output logic             cmdReq,
  output logic [7:0]       cmdByte,
  input  logic             cmdAck,
  input  logic             drdyN,
  output logic             syncOut,
  output logic             busy,
  output logic             calDone,
  output logic             calError
);

  localparam int TMO_W = $clog2(TMO_CYCLES + 1);
  localparam int CNT_W = (TMO_W > DLY_W) ? TMO_W : DLY_W;

  stepInfo_t curStep;
  dpStrobe_t strobe;
  logic      cntZero;
  logic      drdyFall;

  cal_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .calStart (calStart),
    .cmdAck   (cmdAck),
    .cntZero  (cntZero),
    .drdyFall (drdyFall),
    .cmdReq   (cmdReq),
    .busy     (busy),
    .calDone  (calDone),
    .calError (calError),
    .curStep  (curStep),
    .strobe   (strobe)
  );

  cal_seq_dp #(
    .DLY_W       (DLY_W),
    .CNT_W       (CNT_W),
    .TMO_CYCLES  (TMO_CYCLES),
    .SYNC_STAGES (SYNC_STAGES),
    .SHORT_CFG0  (SHORT_CFG0),
    .SHORT_CFG1  (SHORT_CFG1),
    .FULL_CFG0   (FULL_CFG0),
    .FULL_CFG1   (FULL_CFG1)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .curStep     (curStep),
    .origCfg0    (origCfg0),
    .origCfg1    (origCfg1),
    .settleDelay (settleDelay),
    .drdyN       (drdyN),
    .cmdByte     (cmdByte),
    .cntZero     (cntZero),
    .drdyFall    (drdyFall),
    .syncOut     (syncOut)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cmdReq && !cmdAck |=> cmdReq && $stable(cmdByte)); // R12

  AST_SYNC_COVERS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> syncOut); // R2

  AST_IDLE_NO_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !$past(calStart) |-> !syncOut); // R1

endmodule

// File: tb/tb_cal_seq.sv
module tb_cal_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TB_DLY_W   = 8;
  localparam int TB_TMO     = 400;
  localparam logic [7:0] SH0 = 8'hA2, SH1 = 8'h18, FU0 = 8'hA2, FU1 = 8'h20;

  logic clk = 1'b0, rstN = 1'b0, calStart = 1'b0, cmdAck = 1'b0, drdyN = 1'b1;
  logic [7:0] origCfg0 = 8'h00, origCfg1 = 8'h00;
  logic [TB_DLY_W-1:0] settleDelay = '0;
  logic cmdReq, syncOut, busy, calDone, calError;
  logic [7:0] cmdByte;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  int ackLat = 0, drdyLag = 1;
  bit drdyMute = 0;
  logic [7:0] byteLog [64];
  int ackCyc [64];
  int nBytes = 0;
  logic syncAtFirst = 1'b0;
  int latCnt = 0, drdyTimer = 0, drdyLowCnt = 0;
  bit waitWin = 0, holdPending = 0;
  logic [7:0] heldByte = 8'h00;
  int r5Bad = 0, r12Bad = 0;

  cal_seq #(.DLY_W(TB_DLY_W), .TMO_CYCLES(TB_TMO), .SYNC_STAGES(2),
            .SHORT_CFG0(SH0), .SHORT_CFG1(SH1), .FULL_CFG0(FU0), .FULL_CFG1(FU1)) dut (
    .clk(clk), .rstN(rstN), .calStart(calStart), .origCfg0(origCfg0), .origCfg1(origCfg1),
    .settleDelay(settleDelay), .cmdReq(cmdReq), .cmdByte(cmdByte), .cmdAck(cmdAck),
    .drdyN(drdyN), .syncOut(syncOut), .busy(busy), .calDone(calDone), .calError(calError));

  always #(CLK_PERIOD/2) clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Expected stream: two phases of ten bytes, then a four-byte write-back
  function automatic logic [7:0] expByte(input int i, input logic [7:0] o0, input logic [7:0] o1);
    int p, l;
    if (i >= 20) begin
      case (i - 20) 0: return 8'h41; 1: return 8'h01; 2: return o0; default: return o1; endcase
    end
    p = i / 10; l = i % 10;
    case (l)
      0: return 8'h41;
      1: return 8'h01;
      2: return p ? FU0 : SH0;
      3: return p ? FU1 : SH1;
      4, 7: return 8'h11;
      5: return 8'h04;
      8: return p ? 8'h61 : 8'h60;
      default: return 8'h10;
    endcase
  endfunction

  function automatic string tagFor(input int i);
    if (i < 4)  return "R3 short config write";
    if (i < 7)  return "R4 settle commands";
    if (i < 10) return "R6 offset commands";
    if (i < 20) return "R7 gain phase";
    return "R9 write-back";
  endfunction

  // SPI master and converter model, all driven at the falling clock edge
  initial forever begin
    @(negedge clk);
    if (holdPending && !(cmdReq && cmdByte == heldByte)) r12Bad++;
    holdPending = 0;
    if (drdyLowCnt > 0) begin
      drdyLowCnt--;
      if (drdyLowCnt == 0) drdyN = 1'b1;
    end else if (drdyTimer > 0) begin
      drdyTimer--;
      if (drdyTimer == 0) begin drdyN = 1'b0; drdyLowCnt = 3; waitWin = 0; end
    end
    if (waitWin && cmdReq) r5Bad++;
    if (cmdReq) begin
      if (latCnt >= ackLat) begin
        cmdAck = 1'b1;
        latCnt = 0;
        if (nBytes == 0) syncAtFirst = syncOut;
        if (nBytes < 64) begin byteLog[nBytes] = cmdByte; ackCyc[nBytes] = cyc; end
        nBytes++;
        if (cmdByte == 8'h10) begin
          waitWin = 1;
          if (!drdyMute) drdyTimer = drdyLag;
        end
      end else begin
        cmdAck = 1'b0;
        latCnt++;
        holdPending = 1;
        heldByte = cmdByte;
      end
    end else begin
      cmdAck = 1'b0;
      latCnt = 0;
    end
  end

  task automatic runCal(input logic [7:0] o0, input logic [7:0] o1, input int dly,
                        input int lat, input int lag, input bit mute, input bit poke);
    int startCyc, endCyc, guard;
    nBytes = 0; r5Bad = 0; r12Bad = 0; ackLat = lat; drdyLag = lag; drdyMute = mute;
    drdyTimer = 0; waitWin = 0; syncAtFirst = 1'b0;
    origCfg0 = o0; origCfg1 = o1; settleDelay = dly[TB_DLY_W-1:0];
    @(negedge clk); calStart = 1'b1; startCyc = cyc;
    @(negedge clk); calStart = 1'b0;
    check(busy && syncOut, "R2 busy and sync after start", {busy, syncOut}, 3);
    guard = 0;
    while (busy && guard < 20000) begin
      @(negedge clk); guard++;
      if (poke && guard == 40) begin calStart = 1'b1; origCfg0 = ~o0; origCfg1 = ~o1; end
      if (poke && guard == 41) calStart = 1'b0;
    end
    endCyc = cyc;
    check(!busy, "R9 busy released", busy, 0);
    check(!syncOut, "R2 sync released with busy", syncOut, 0);
    if (mute) begin
      check(nBytes == 7, "R10 no bytes after timeout", nBytes, 7);
      check(calError && !calDone, "R10 error flag", {calDone, calError}, 1);
      check(endCyc - startCyc >= TB_TMO, "R10 timeout length", endCyc - startCyc, TB_TMO);
    end else begin
      check(nBytes == 24, "R9 byte count", nBytes, 24);
      for (int i = 0; i < 24 && i < nBytes; i++)
        check(byteLog[i] == expByte(i, o0, o1), tagFor(i), byteLog[i], expByte(i, o0, o1));
      check(calDone && !calError, "R9 done flag", {calDone, calError}, 2);
      if (nBytes >= 15) begin
        check(ackCyc[4] - ackCyc[3] >= dly + 1, "R8 delay offset phase", ackCyc[4] - ackCyc[3], dly + 1);
        check(ackCyc[14] - ackCyc[13] >= dly + 1, "R8 delay gain phase", ackCyc[14] - ackCyc[13], dly + 1);
      end
      check(syncAtFirst == 1'b1, "R2 sync high before first byte", syncAtFirst, 1);
      if (poke)
        check(nBytes == 24 && byteLog[22] == o0 && byteLog[23] == o1,
              "R11 start and config change ignored while busy", byteLog[22], o0);
    end
    check(r5Bad == 0, "R5 no request while waiting", r5Bad, 0);
    check(r12Bad == 0, "R12 byte held until ack", r12Bad, 0);
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk);
    check({busy, calDone, calError, cmdReq, syncOut} == 5'b0, "R1 reset state",
          {busy, calDone, calError, cmdReq, syncOut}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check({busy, calDone, calError, cmdReq, syncOut} == 5'b0, "R1 idle after reset",
          {busy, calDone, calError, cmdReq, syncOut}, 0);
    k = 0;
    foreach (byteLog[j]) byteLog[j] = 8'h00;
    for (int d = 0; d < 3; d++)
      for (int l = 0; l < 3; l++)
        for (int g = 0; g < 2; g++) begin
          runCal(8'h10 + 8'(k * 7), ~(8'h10 + 8'(k * 7)), (d == 0) ? 0 : d * 3 - 1,
                 (l == 2) ? 3 : l, g ? 6 : 1, 0, 0);
          k++;
        end
    runCal(8'h5A, 8'hC3, 4, 2, 3, 0, 1);
    runCal(8'h33, 8'h44, 1, 0, 2, 1, 0);
    runCal(8'hE1, 8'h07, 2, 1, 4, 0, 0);
    check(!calError, "R10 error cleared by new start", calError, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R10 watchdog expired: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule